// File: doc/BRIEF.md
# Burst SRAM Read Sequencer

This block generates the control lines for one burst read from a synchronous, pipelined-burst static RAM. A single enable input, `run`, starts the read and keeps it going. While `run` stays high the controller steps through an address phase and a wait phase, then stays in a data phase. Dropping `run` sends it back to idle from any state.

In the address phase the block drives a start address, which it captured when the read began, onto the memory address bus. In every other phase that bus is released to high impedance. The two active-low address strobes, the burst-advance line and the output enable each follow a fixed level pattern in each phase. The chip enable is held low for the whole read. While the controller is in the data phase, it flags that the memory's 32-bit read data is valid and registers that data on every clock edge.

Top module: `burst_rd_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the controller in idle. In idle all five active-low controls (`strobe_cpu_n`, `strobe_ctl_n`, `burst_adv_n`, `out_en_n`, `chip_en_n`) are 1, `addr_en` is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: While `run` is low, the controller stays idle and its outputs keep the idle levels of R1.
- R3: From idle, an edge with `run` high enters the address phase. In this phase both strobes and `burst_adv_n` are 0, `out_en_n` is 1, and `mem_addr` equals the `start_addr` sampled at that edge. Later changes to `start_addr` do not alter `mem_addr`.
- R4: From the address phase, an edge with `run` high enters the wait phase. In this phase `strobe_cpu_n` is 1, `strobe_ctl_n` is 0, `burst_adv_n` is 1 and `out_en_n` is 1.
- R5: From the wait phase, an edge with `run` high enters the data phase. In this phase both strobes are 1, `burst_adv_n` and `out_en_n` are 0, and `rd_valid` is 1. The data phase lasts as long as `run` stays high.
- R6: An edge with `run` low returns the controller to idle from the address, wait or data phase.
- R7: `rd_data` takes the value of `mem_rdata` at every edge at which the controller is in the data phase, and holds its value at all other edges.
- R8: `chip_en_n` is 0 in the address, wait and data phases and 1 in idle.
- R9: `addr_en` is 1 only in the address phase. The address bus is driven only while `addr_en` is 1 and is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Starts the burst read when high, aborts it when low |
| start_addr | input | 16 | Start address, sampled when the read begins |
| mem_rdata | input | 32 | Read data from the memory |
| strobe_cpu_n | output | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | output | 1 | Controller-side address strobe, active low |
| burst_adv_n | output | 1 | Burst advance, active low |
| out_en_n | output | 1 | Memory output enable, active low |
| chip_en_n | output | 1 | Chip enable, active low |
| addr_en | output | 1 | High while the address bus is driven |
| mem_addr | output | 16 | Address bus, high impedance outside the address phase |
| rd_valid | output | 1 | Memory read data valid (data phase) |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds the block with its default widths: a 16-bit address and 32-bit data. At these widths, start addresses and data words with their top and bottom bits set can be told apart on the ports. That makes a wrongly latched address or a dropped data bit visible. Aborts are placed in each of the three active phases, and the data phase is held long enough for several distinct words to be captured before one final capture on the exit edge.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_DATA = 2'd3
    } brc_state_e;

    typedef struct packed {
        logic cpu_stb_n;
        logic ctl_stb_n;
        logic adv_n;
        logic oe_n;
        logic ce_n;
        logic addr_en;
        logic valid;
    } brc_ctl_t;

    // Level pattern of every control line for one phase.
    function automatic brc_ctl_t phase_levels(brc_state_e s);
        brc_ctl_t c;
        c = '{cpu_stb_n: 1'b1, ctl_stb_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1,
              ce_n: 1'b1, addr_en: 1'b0, valid: 1'b0};
        case (s)
            ST_ADDR: begin
                c.cpu_stb_n = 1'b0;
                c.ctl_stb_n = 1'b0;
                c.adv_n     = 1'b0;
                c.ce_n      = 1'b0;
                c.addr_en   = 1'b1;
            end
            ST_WAIT: begin
                c.ctl_stb_n = 1'b0;
                c.ce_n      = 1'b0;
            end
            ST_DATA: begin
                c.adv_n = 1'b0;
                c.oe_n  = 1'b0;
                c.ce_n  = 1'b0;
                c.valid = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/brc_seq.sv
module brc_seq
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [ADDR_W-1:0] start_addr,
    output brc_state_e        state_o,
    output brc_ctl_t          ctl_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        brc_state_e        st;
        brc_ctl_t          ctl;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (run) begin
                    seq_d.st   = ST_ADDR;
                    seq_d.addr = start_addr;
                end
            end
            ST_ADDR: seq_d.st = run ? ST_WAIT : ST_IDLE;
            ST_WAIT: seq_d.st = run ? ST_DATA : ST_IDLE;
            ST_DATA: seq_d.st = run ? ST_DATA : ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
        seq_d.ctl = phase_levels(seq_d.st);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st   <= ST_IDLE;
            seq_q.ctl  <= phase_levels(ST_IDLE);
            seq_q.addr <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.st;
    assign ctl_o   = seq_q.ctl;
    assign addr_o  = seq_q.addr;

    // R6
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> seq_q.st == ST_IDLE);

    // R4
    addr_then_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == ST_ADDR && run) |=> seq_q.st == ST_WAIT);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == ST_DATA && run) |=> seq_q.st == ST_DATA);

    // R3
    addr_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == ST_IDLE && run) |=> seq_q.addr == $past(start_addr));

endmodule

// File: rtl/brc_capture.sv
module brc_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (en) data_d = din;
    end

    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= data_d;
    end

    assign dout = data_q;

    // R7
    capture_take_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> data_q == $past(din));

    // R7
    capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(data_q));

endmodule

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              strobe_cpu_n,
    output logic              strobe_ctl_n,
    output logic              burst_adv_n,
    output logic              out_en_n,
    output logic              chip_en_n,
    output logic              addr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    brc_state_e        state;
    brc_ctl_t          ctl;
    logic [ADDR_W-1:0] addr_lat;

    brc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .start_addr(start_addr),
        .state_o   (state),
        .ctl_o     (ctl),
        .addr_o    (addr_lat)
    );

    brc_capture #(.DATA_W(DATA_W)) u_cap (
        .clk (clk),
        .rst (rst),
        .en  (ctl.valid),
        .din (mem_rdata),
        .dout(rd_data)
    );

    assign strobe_cpu_n = ctl.cpu_stb_n;
    assign strobe_ctl_n = ctl.ctl_stb_n;
    assign burst_adv_n  = ctl.adv_n;
    assign out_en_n     = ctl.oe_n;
    assign chip_en_n    = ctl.ce_n;
    assign addr_en      = ctl.addr_en;
    assign rd_valid     = ctl.valid;
    assign mem_addr     = ctl.addr_en ? addr_lat : 'z;

    // R9
    addr_only_strobed_chk: assert property (@(posedge clk) disable iff (rst)
        addr_en |-> (!strobe_cpu_n && !strobe_ctl_n && (state == ST_ADDR)));

    // R5
    valid_with_oe_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!out_en_n && strobe_cpu_n && strobe_ctl_n));

    // R8
    ce_active_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> !chip_en_n);

    // R5
    data_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(state) == ST_WAIT);

endmodule

// File: tb/test_burst_rd_ctrl.sv
module test_burst_rd_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [15:0] start_addr = '0;
    logic [31:0] mem_rdata = '0;
    logic        strobe_cpu_n, strobe_ctl_n, burst_adv_n, out_en_n, chip_en_n;
    logic        addr_en, rd_valid;
    logic [15:0] mem_addr;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    burst_rd_ctrl i_burst_rd_ctrl (
        .clk(clk), .rst(rst), .run(run), .start_addr(start_addr),
        .mem_rdata(mem_rdata), .strobe_cpu_n(strobe_cpu_n),
        .strobe_ctl_n(strobe_ctl_n), .burst_adv_n(burst_adv_n),
        .out_en_n(out_en_n), .chip_en_n(chip_en_n), .addr_en(addr_en),
        .mem_addr(mem_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Expected {cpu, ctl, adv, oe, ce, addr_en, valid} per phase:
    // 0 idle, 1 address, 2 wait, 3 data.
    function automatic logic [6:0] exp_lines(int ph);
        case (ph)
            1:       return 7'b000_1_0_1_0;
            2:       return 7'b101_1_0_0_0;
            3:       return 7'b110_0_0_0_1;
            default: return 7'b111_1_1_0_0;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_lines(int ph, string req);
        logic [6:0] act;
        act = {strobe_cpu_n, strobe_ctl_n, burst_adv_n, out_en_n,
               chip_en_n, addr_en, rd_valid};
        checks++;
        if (act !== exp_lines(ph)) begin
            errors++;
            $display("FAIL %s phase %0d lines act=%b exp=%b", req, ph, act, exp_lines(ph));
        end
    endtask

    task automatic chk_val(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        run = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_lines(0, "R1");
        chk_val("R1 rd_data", rd_data, 32'h0);
    endtask

    task automatic t_idle_hold();
        run = 1'b0;
        mem_rdata = 32'hDEAD_BEEF;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_lines(0, "R2");
        end
        chk_val("R2 rd_data untouched", rd_data, 32'h0);
    endtask

    task automatic t_full_burst();
        start_addr = 16'h8001;
        run = 1'b1;
        tick();
        chk_lines(1, "R3");
        chk_lines(1, "R8");
        chk_val("R3 mem_addr", {16'h0, mem_addr}, 32'h8001);
        start_addr = 16'h1234;
        #1;
        chk_val("R3 latched addr", {16'h0, mem_addr}, 32'h8001);
        tick();
        chk_lines(2, "R4");
        chk_val("R9 addr_en off in wait", {31'h0, addr_en}, 32'h0);
        mem_rdata = 32'hA000_0001;
        tick();
        chk_lines(3, "R5");
        mem_rdata = 32'hA000_0002;
        tick();
        chk_lines(3, "R5 hold");
        chk_val("R7 capture 1", rd_data, 32'hA000_0002);
        mem_rdata = 32'h8000_00FF;
        tick();
        chk_val("R7 capture 2", rd_data, 32'h8000_00FF);
        mem_rdata = 32'h0F0F_F0F0;
        tick();
        chk_lines(3, "R5 hold long");
        chk_val("R7 capture 3", rd_data, 32'h0F0F_F0F0);
        run = 1'b0;
        mem_rdata = 32'h1357_9BDF;
        tick();
        chk_lines(0, "R6 from data");
        chk_val("R7 exit edge capture", rd_data, 32'h1357_9BDF);
        mem_rdata = 32'hFFFF_FFFF;
        tick();
        chk_val("R7 hold in idle", rd_data, 32'h1357_9BDF);
    endtask

    task automatic t_abort_addr();
        start_addr = 16'hFFFE;
        run = 1'b1;
        tick();
        chk_lines(1, "R3 second start");
        chk_val("R3 new addr", {16'h0, mem_addr}, 32'hFFFE);
        run = 1'b0;
        tick();
        chk_lines(0, "R6 from addr");
        chk_val("R9 released", {31'h0, addr_en}, 32'h0);
    endtask

    task automatic t_abort_wait();
        run = 1'b1;
        tick();
        tick();
        chk_lines(2, "R4 again");
        run = 1'b0;
        mem_rdata = 32'h5555_AAAA;
        tick();
        chk_lines(0, "R6 from wait");
        chk_val("R7 no capture outside data", rd_data, 32'h1357_9BDF);
    endtask

    task automatic t_reset_in_data();
        run = 1'b1;
        tick();
        tick();
        tick();
        chk_lines(3, "R5 before reset");
        rst = 1'b1;
        tick();
        chk_lines(0, "R1 mid burst");
        chk_val("R1 rd_data cleared", rd_data, 32'h0);
        rst = 1'b0;
        run = 1'b0;
        tick();
        chk_lines(0, "R8 idle ce high");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_idle_hold();
        t_full_burst();
        t_abort_addr();
        t_abort_wait();
        t_reset_in_data();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule